// File: doc/BRIEF.md
# End-Fill Selectable Single-Step Shifter

This block moves a data word by exactly one bit position, left or right, and lets a small function code choose what enters the vacated end. The fill can be a constant zero, a copy of the sign bit, the bit that just fell off the other end, or the incoming carry flag. Together these give eight shift variants: logical, arithmetic, plain rotate and rotate through carry, each in both directions. The bit pushed out of the word is offered as the new carry value, and a strobe tells the surrounding status logic when that carry should be captured.

A sequencer that needs a multi-position shift issues the one-step operation repeatedly, feeding the carry result of one step back as the carry input of the next. All outputs are registered, so the result of the inputs presented on one rising edge appears after that edge and is held until the next.

Top module: `endfill_shifter`

## Requirements
- R1: While `rst` is high at a rising edge, `result_o`, `carry_o` and `carry_ld_o` become 0 after that edge.
- R2: Function code bit 3 = 0 selects pass-through: after the edge `result_o` equals the operand, `carry_o` equals `carry_i` and `carry_ld_o` is 0, whatever bits 2:0 hold.
- R3: Function code bit 3 = 1 selects a shift, and `carry_ld_o` is 1 after the edge for every such code.
- R4: Fill field (bits 1:0) = 00 is a logical shift: the vacated bit is 0 in both directions (bit 2 = 1 left, bit 2 = 0 right).
- R5: Fill field = 01 is arithmetic: a right shift puts the old bit W-1 (sign) into bit W-1; a left shift puts 0 into bit 0.
- R6: Fill field = 10 is a rotate: the bit leaving one end enters the opposite end.
- R7: Fill field = 11 is a rotate through carry: the vacated bit takes the value of `carry_i`, at either end.
- R8: For every shift, `carry_o` is the bit shifted out: old bit W-1 for a left shift, old bit 0 for a right shift.
- R9: Each output reflects the inputs sampled at the previous rising edge (one cycle of latency) and inputs arriving between edges do not change it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| opnd_i | input | W (16) | Word to be shifted |
| carry_i | input | 1 | Present carry flag value |
| func_i | input | 4 | Function code: bit 3 enable, bit 2 direction (1 left), bits 1:0 fill kind |
| result_o | output | W (16) | Registered shifted word |
| carry_o | output | 1 | Registered carry-out value |
| carry_ld_o | output | 1 | Registered strobe to load the carry flag |

## Verification
The bench targets words whose end bits differ from each other and from the carry input, since a design that swapped the left and right fill multiplexers, or took the sign from the wrong end, would only show it there; arithmetic left shifts of negative words catch a design that copies the sign into bit 0. Pass-through codes with nonzero low bits and a set carry expose a design that shifts or strobes while disabled, or that zeroes the carry. Rotate-through-carry with both carry values, and all-ones and single-bit words, separate a carry fill from a wrapped bit and catch a carry-out taken from the wrong end.

// File: rtl/endfill_pkg.sv
package endfill_pkg;

  typedef enum logic [1:0] {
    FILL_ZERO  = 2'b00,
    FILL_ARITH = 2'b01,
    FILL_ROT   = 2'b10,
    FILL_CARRY = 2'b11
  } fill_e;

  typedef struct packed {
    logic  en;
    logic  left;
    fill_e fill;
  } shf_func_t;

  localparam int FUNC_W = $bits(shf_func_t);

endpackage

// File: rtl/end_fill_mux.sv
module end_fill_mux
  import endfill_pkg::*;
#(
  parameter bit HI_END = 1'b1
) (
  input  logic  msb_i,
  input  logic  lsb_i,
  input  logic  carry_i,
  input  fill_e sel_i,
  output logic  fill_o
);

  logic arith_bit;
  logic wrap_bit;

  generate
    if (HI_END) begin : g_hi
      // right shift enters at the top: sign copy, wrapped bit 0
      assign arith_bit = msb_i;
      assign wrap_bit  = lsb_i;
    end else begin : g_lo
      // left shift enters at bit 0: arithmetic fills zero
      assign arith_bit = 1'b0;
      assign wrap_bit  = msb_i;
    end
  endgenerate

  always_comb begin
    unique case (sel_i)
      FILL_ZERO:  fill_o = 1'b0;
      FILL_ARITH: fill_o = arith_bit;
      FILL_ROT:   fill_o = wrap_bit;
      FILL_CARRY: fill_o = carry_i;
      default:    fill_o = 1'b0;
    endcase
  end

endmodule

// File: rtl/shift_core.sv
module shift_core #(
  parameter int W = 16
) (
  input  logic [W-1:0] opnd_i,
  input  logic         en_i,
  input  logic         left_i,
  input  logic         fill_hi_i,
  input  logic         fill_lo_i,
  input  logic         carry_i,
  output logic [W-1:0] res_o,
  output logic         cout_o
);

  logic out_bit;

  // 2-to-1 pick of the bit leaving the word
  assign out_bit = left_i ? opnd_i[W-1] : opnd_i[0];

  always_comb begin
    if (!en_i) begin
      res_o  = opnd_i;
      cout_o = carry_i;
    end else if (left_i) begin
      res_o  = {opnd_i[W-2:0], fill_lo_i};
      cout_o = out_bit;
    end else begin
      res_o  = {fill_hi_i, opnd_i[W-1:1]};
      cout_o = out_bit;
    end
  end

endmodule

// File: rtl/endfill_shifter.sv
module endfill_shifter
  import endfill_pkg::*;
#(
  parameter int W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [W-1:0]      opnd_i,
  input  logic              carry_i,
  input  logic [FUNC_W-1:0] func_i,
  output logic [W-1:0]      result_o,
  output logic              carry_o,
  output logic              carry_ld_o
);

  shf_func_t    fc;
  logic         fill_hi;
  logic         fill_lo;
  logic [W-1:0] res_d;
  logic         cout_d;

  assign fc = shf_func_t'(func_i);

  end_fill_mux #(.HI_END(1'b1)) u_fill_hi (
    .msb_i  (opnd_i[W-1]),
    .lsb_i  (opnd_i[0]),
    .carry_i(carry_i),
    .sel_i  (fc.fill),
    .fill_o (fill_hi)
  );

  end_fill_mux #(.HI_END(1'b0)) u_fill_lo (
    .msb_i  (opnd_i[W-1]),
    .lsb_i  (opnd_i[0]),
    .carry_i(carry_i),
    .sel_i  (fc.fill),
    .fill_o (fill_lo)
  );

  shift_core #(.W(W)) u_core (
    .opnd_i   (opnd_i),
    .en_i     (fc.en),
    .left_i   (fc.left),
    .fill_hi_i(fill_hi),
    .fill_lo_i(fill_lo),
    .carry_i  (carry_i),
    .res_o    (res_d),
    .cout_o   (cout_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      result_o   <= '0;
      carry_o    <= 1'b0;
      carry_ld_o <= 1'b0;
    end else begin
      result_o   <= res_d;
      carry_o    <= cout_d;
      carry_ld_o <= fc.en;
    end
  end

endmodule

// File: rtl/endfill_shifter_chk.sv
module endfill_shifter_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst,
  input logic [W-1:0] opnd_i,
  input logic         carry_i,
  input logic [3:0]   func_i,
  input logic [W-1:0] result_o,
  input logic         carry_o,
  input logic         carry_ld_o
);

  logic primed;

  always_ff @(posedge clk) begin
    if (rst) primed <= 1'b0;
    else     primed <= 1'b1;
  end

  p_reset_clear_r1: assert property (@(posedge clk)
    $past(rst) |-> (result_o == '0 && !carry_o && !carry_ld_o));

  p_pass_through_r2: assert property (@(posedge clk) disable iff (rst)
    (primed && !$past(func_i[3])) |->
      (result_o == $past(opnd_i) && carry_o == $past(carry_i) && !carry_ld_o));

  p_strobe_on_shift_r3: assert property (@(posedge clk) disable iff (rst)
    (primed && $past(func_i[3])) |-> carry_ld_o);

  p_arith_right_sign_r5: assert property (@(posedge clk) disable iff (rst)
    (primed && $past(func_i) == 4'b1001) |-> (result_o[W-1] == $past(opnd_i[W-1])));

  p_rotate_left_wrap_r6: assert property (@(posedge clk) disable iff (rst)
    (primed && $past(func_i) == 4'b1110) |-> (result_o[0] == $past(opnd_i[W-1])));

  p_carry_fill_r7: assert property (@(posedge clk) disable iff (rst)
    (primed && $past(func_i[3]) && $past(func_i[1:0]) == 2'b11) |->
      (($past(func_i[2]) ? result_o[0] : result_o[W-1]) == $past(carry_i)));

  p_carry_out_left_r8: assert property (@(posedge clk) disable iff (rst)
    (primed && $past(func_i[3:2]) == 2'b11) |-> (carry_o == $past(opnd_i[W-1])));

  p_carry_out_right_r8: assert property (@(posedge clk) disable iff (rst)
    (primed && $past(func_i[3:2]) == 2'b10) |-> (carry_o == $past(opnd_i[0])));

endmodule

bind endfill_shifter endfill_shifter_chk #(.W(W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .opnd_i    (opnd_i),
  .carry_i   (carry_i),
  .func_i    (func_i),
  .result_o  (result_o),
  .carry_o   (carry_o),
  .carry_ld_o(carry_ld_o)
);

// File: tb/endfill_shifter_bench.sv
module endfill_shifter_bench;

  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] opnd = '0;
  logic         cin = 1'b0;
  logic [3:0]   func = 4'h0;
  logic [W-1:0] result;
  logic         cout;
  logic         cld;

  int checks = 0;
  int failures = 0;

  always #10 clk = ~clk;

  endfill_shifter #(.W(W)) u_endfill_shifter (
    .clk       (clk),
    .rst       (rst),
    .opnd_i    (opnd),
    .carry_i   (cin),
    .func_i    (func),
    .result_o  (result),
    .carry_o   (cout),
    .carry_ld_o(cld)
  );

  // expected {strobe, carry, result} from the requirement text
  function automatic logic [W+1:0] model(input logic [W-1:0] a, input logic c,
                                         input logic [3:0] f);
    logic ins;
    if (!f[3]) return {1'b0, c, a};
    case (f[1:0])
      2'b00: ins = 1'b0;
      2'b01: ins = f[2] ? 1'b0 : a[W-1];
      2'b10: ins = f[2] ? a[W-1] : a[0];
      default: ins = c;
    endcase
    if (f[2]) return {1'b1, a[W-1], a[W-2:0], ins};
    return {1'b1, a[0], ins, a[W-1:1]};
  endfunction

  function automatic string tag_of(input logic [3:0] f);
    if (!f[3]) return "R2";
    case (f[1:0])
      2'b00: return "R4";
      2'b01: return "R5";
      2'b10: return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic compare(input string tag, input logic [W+1:0] exp);
    checks++;
    if ({cld, cout, result} !== exp) begin
      failures++;
      $display("FAIL %s: got ld=%0b c=%0b res=%h expected ld=%0b c=%0b res=%h",
               tag, cld, cout, result, exp[W+1], exp[W], exp[W-1:0]);
    end
  endtask

  task automatic apply(input logic [W-1:0] a, input logic c, input logic [3:0] f);
    logic [W+1:0] exp;
    @(negedge clk);
    opnd = a; cin = c; func = f;
    exp = model(a, c, f);
    @(negedge clk);
    compare(tag_of(f), exp);
    // R3 and R8 judged separately on the same sample
    if (f[3]) begin
      checks++;
      if (cld !== 1'b1 || cout !== (f[2] ? a[W-1] : a[0])) begin
        failures++;
        $display("FAIL R3/R8: got ld=%0b c=%0b expected ld=1 c=%0b",
                 cld, cout, f[2] ? a[W-1] : a[0]);
      end
    end
  endtask

  initial begin : watchdog
    #(20 * 200000);
    failures++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : main
    logic [W-1:0] ra;
    logic [W+1:0] hold;
    void'($urandom(32'h5eed_1234));
    opnd = 16'hFFFF; cin = 1'b1; func = 4'hE;
    repeat (3) @(negedge clk);
    // R1: reset clears all outputs even with active inputs
    compare("R1", '0);
    rst = 1'b0;

    // R2: pass-through with nonzero low bits and carry set
    apply(16'hA5C3, 1'b1, 4'b0111);
    apply(16'h8001, 1'b0, 4'b0010);

    // directed: every shift on end-bit patterns and both carries
    for (int f = 8; f < 16; f++) begin
      apply(16'h8001, 1'b0, 4'(f));
      apply(16'h8001, 1'b1, 4'(f));
      apply(16'h4002, 1'b1, 4'(f));
      apply(16'hFFFF, 1'b0, 4'(f));
      apply(16'h0000, 1'b1, 4'(f));
    end
    // R5: arithmetic left on a negative word puts 0 in bit 0
    apply(16'hC000, 1'b1, 4'b1101);
    // R7: carry enters at the top on right rotate-through-carry
    apply(16'h0000, 1'b1, 4'b1011);

    // R9: output holds when inputs change between edges
    apply(16'h1234, 1'b0, 4'b1100);
    hold = model(16'h1234, 1'b0, 4'b1100);
    #3 opnd = 16'hFFFF; func = 4'b1011;
    #2 compare("R9", hold);

    // constrained random mix
    for (int i = 0; i < 3000; i++) begin
      ra = 16'($urandom);
      apply(ra, 1'($urandom), 4'($urandom));
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule